// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps time as a 32-bit count of elapsed seconds. A prescaler running on the 32.768 kHz timekeeping clock makes one tick every 2^DIV_BITS cycles. The default of 15 bits gives one tick per second. Each tick adds one to the seconds count. Software controls the block through a small byte-wide register port. It can enable the clock, freeze the count so a new time can be loaded, and hold the prescaler at zero so that a restart lands on a whole second. The time reads back one byte at a time, from the live value.

A 32-bit alarm value is compared against the running time. Once the time reaches or passes the alarm, a registered request is raised on the next clock edge. An external enable then gates it onto an active-low interrupt line. Rewriting any alarm byte drops the request for at least one cycle, after which the compare is evaluated again.

There are two reset inputs. A power-on reset clears everything. A system reset leaves the enable, the freeze bit, the prescaler and the time untouched, so timekeeping carries on through it.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After power-on reset, the control register reads 0x00 and all four time bytes read 0x00. All four alarm bytes read 0xFF and alarm_irq_n is high.
- R2: Register map on addr. Address 0 is control: bit 7 run enable, bit 6 prescaler clear, bit 3 freeze; the other bits read 0. Addresses 4 to 7 are time bytes, 8 to 11 are alarm bytes, least significant byte at the lowest address. Any other address reads 0x00 and ignores writes.
- R3: While enabled and not frozen, the time increments by exactly one on every 2^DIV_BITS-th edge of clk.
- R4: A write to a time byte changes only that byte, and only while freeze is 1. Time writes made while freeze is 0 are ignored. While frozen the time holds.
- R5: While prescaler clear is 1, the prescaler stays at zero and no increment happens. If a control write at edge k leaves clear at 0 and the clock running, the first increment occurs at edge k+2^DIV_BITS.
- R6: Freezing does not stop the prescaler. After unfreezing without a prescaler clear, increments stay aligned to the prescaler phase that was already running.
- R7: With run enable at 0, the prescaler and the time hold, and no alarm request is raised.
- R8: A system reset leaves run enable, freeze, the prescaler and the time unchanged, and counting continues during it. It sets the alarm to 0xFFFFFFFF, clears prescaler clear and the request, and ignores register writes.
- R9: When enabled and time >= alarm at an edge, alarm_irq_n is low after that edge, provided irq_en is 1.
- R10: A write to any alarm byte makes alarm_irq_n high after that write's edge. From the next edge the request again follows the compare.
- R11: With irq_en at 0, alarm_irq_n is high whatever the request state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears all state |
| sys_rst_n | input | 1 | Synchronous active-low system reset, spares timekeeping state |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| irq_en | input | 1 | External interrupt enable |
| rdata | output | 8 | Read data for addr, combinational |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A wrong prescaler phase shows up as a time byte changing one or more cycles early or late. The bench pins this down exactly to the cycle, both after a cleared restart and across a freeze without a clear. A corrupted time or alarm register shows on the next read of that byte, and a wrong compare shows as alarm_irq_n differing one edge after the time crosses the alarm. State lost through a system reset appears as time bytes that stop advancing or jump back during the reset pulse.

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       irq_en,
  output logic [7:0] rdata,
  output logic       alarm_irq_n
);

  logic                en_q, pclr_q, stop_q, flag_q;
  logic [DIV_BITS-1:0] presc_q;
  logic [31:0]         time_q, alarm_q;

  wire sel_ctrl = (addr == 4'd0);
  wire sel_time = (addr[3:2] == 2'b01);
  wire sel_alm  = (addr[3:2] == 2'b10);
  wire wr_ok    = wr_en && sys_rst_n;
  wire tick     = en_q && !pclr_q && (presc_q == '1);
  wire reached  = (time_q >= alarm_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      presc_q <= '0;
      time_q  <= '0;
    end else begin
      if (wr_ok && sel_ctrl) begin
        en_q   <= wdata[7];
        stop_q <= wdata[3];
      end
      if (pclr_q)
        presc_q <= '0;
      else if (en_q)
        presc_q <= presc_q + 1'b1;
      if (tick && !stop_q)
        time_q <= time_q + 32'd1;
      else if (stop_q && wr_ok && sel_time)
        time_q[{addr[1:0], 3'b000} +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pclr_q  <= 1'b0;
      alarm_q <= '1;
      flag_q  <= 1'b0;
    end else if (!sys_rst_n) begin
      pclr_q  <= 1'b0;
      alarm_q <= '1;
      flag_q  <= 1'b0;
    end else begin
      if (wr_en && sel_ctrl)
        pclr_q <= wdata[6];
      if (wr_en && sel_alm)
        alarm_q[{addr[1:0], 3'b000} +: 8] <= wdata;
      flag_q <= !(wr_en && sel_alm) && en_q && reached;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (sel_ctrl)
      rdata = {en_q, pclr_q, 2'b00, stop_q, 3'b000};
    else if (sel_time)
      rdata = time_q[{addr[1:0], 3'b000} +: 8];
    else if (sel_alm)
      rdata = alarm_q[{addr[1:0], 3'b000} +: 8];
  end

  assign alarm_irq_n = !(flag_q && irq_en);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (tick && !stop_q) |=> time_q == $past(time_q) + 32'd1);

  // R4
  time_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!(tick && !stop_q) && !(stop_q && wr_en && sel_time)) |=> $stable(time_q));

  // R5
  presc_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    pclr_q |=> presc_q == '0);

  // R8
  sys_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> (alarm_q == '1 && !pclr_q && !flag_q));

  // R9
  alarm_raise_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && !(wr_en && sel_alm) && en_q && reached) |=> flag_q);

  // R10
  alarm_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && sel_alm) |=> alarm_irq_n);

endmodule

// File: tb/rtc_seconds_alarm_test.sv
module rtc_seconds_alarm_test;
  localparam int DB = 4;
  localparam int PER = 1 << DB;

  logic clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b1, wr_en = 1'b0, irq_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic alarm_irq_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rtc_seconds_alarm #(.DIV_BITS(DB)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .irq_en(irq_en), .rdata(rdata), .alarm_irq_n(alarm_irq_n));

  logic m_en, m_pclr, m_stop, m_flag;
  logic [DB-1:0] m_pre;
  logic [31:0] m_time, m_alm;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_en <= 0; m_pclr <= 0; m_stop <= 0; m_flag <= 0;
      m_pre <= '0; m_time <= '0; m_alm <= '1;
    end else begin
      automatic bit tk = m_en && !m_pclr && (m_pre == '1);
      m_pre <= m_pclr ? '0 : (m_en ? m_pre + 1'b1 : m_pre);
      if (tk && !m_stop) m_time <= m_time + 1;
      else if (m_stop && wr_en && sys_rst_n && addr >= 4 && addr <= 7)
        m_time[(addr-4)*8 +: 8] <= wdata;
      if (wr_en && sys_rst_n && addr == 0) begin
        m_en <= wdata[7]; m_stop <= wdata[3]; m_pclr <= wdata[6];
      end
      if (!sys_rst_n) begin
        m_pclr <= 0; m_alm <= '1; m_flag <= 0;
      end else begin
        if (wr_en && addr >= 8 && addr <= 11) m_alm[(addr-8)*8 +: 8] <= wdata;
        m_flag <= !(wr_en && addr >= 8 && addr <= 11) && m_en && (m_time >= m_alm);
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 0) return {m_en, m_pclr, 2'b00, m_stop, 3'b000};
    if (a >= 4 && a <= 7) return m_time[(a-4)*8 +: 8];
    if (a >= 8 && a <= 11) return m_alm[(a-8)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input logic [3:0] a, input logic [7:0] d,
                      input bit srn, input bit ie, input string tag);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; sys_rst_n = srn; irq_en = ie;
    #1;
    chk(tag, {24'd0, rdata}, {24'd0, exp_rd(a)});
    chk(tag, {31'd0, alarm_irq_n}, {31'd0, !(m_flag && ie)});
  endtask

  task automatic idle(input int n, input logic [3:0] a, input bit ie, input string tag);
    for (int i = 0; i < n; i++) step(0, a, 8'h00, 1, ie, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      step(0, a[3:0], 0, 1, 1, "R1");
      chk("R1", {24'd0, rdata}, (a >= 8) ? 32'hFF : 32'h00);
    end
    chk("R1", {31'd0, alarm_irq_n}, 32'd1);

    // R5 cleared restart: first increment 2^DB edges after the restart write
    step(1, 0, 8'hC8, 1, 1, "R5");
    step(1, 4, 8'hFE, 1, 1, "R4");
    step(1, 0, 8'h80, 1, 1, "R5");
    idle(PER, 4, 1, "R5");
    chk("R5", {24'd0, rdata}, 32'hFE);
    step(0, 4, 0, 1, 1, "R5");
    chk("R5", {24'd0, rdata}, 32'hFF);

    // R4 time write while running is ignored
    step(1, 5, 8'h55, 1, 1, "R4");
    step(0, 5, 0, 1, 1, "R4");
    chk("R4", {24'd0, rdata}, 32'h00);

    // R6 freeze without clear keeps prescaler phase
    idle(5, 4, 1, "R6");
    step(1, 0, 8'h88, 1, 1, "R6");
    idle(7, 4, 1, "R6");
    step(1, 0, 8'h80, 1, 1, "R6");
    idle(3 * PER, 4, 1, "R6");

    // R7 disabled holds
    step(1, 0, 8'h00, 1, 1, "R7");
    idle(3 * PER, 4, 1, "R7");
    step(1, 0, 8'h80, 1, 1, "R7");

    // R8 system reset keeps time counting, restores alarm
    step(1, 8, 8'h00, 1, 1, "R8");
    for (int i = 0; i < 2 * PER; i++) step(1, 5, 8'hAA, 0, 1, "R8");
    step(0, 8, 0, 1, 1, "R8");
    chk("R8", {24'd0, rdata}, 32'hFF);
    step(0, 0, 0, 1, 1, "R8");
    chk("R8", {24'd0, rdata}, 32'h80);

    // R9 alarm reached
    step(1, 0, 8'h88, 1, 1, "R9");
    step(1, 4, 8'h10, 1, 1, "R9");
    for (int b = 5; b <= 11; b++) step(1, b[3:0], 8'h00, 1, 1, "R9");
    step(1, 8, 8'h12, 1, 1, "R9");
    step(1, 0, 8'h80, 1, 1, "R9");
    idle(3 * PER, 4, 1, "R9");
    chk("R9", {31'd0, alarm_irq_n}, 32'd0);

    // R10 alarm write drops request for one cycle
    step(1, 9, 8'h00, 1, 1, "R10");
    step(0, 4, 0, 1, 1, "R10");
    chk("R10", {31'd0, alarm_irq_n}, 32'd1);
    step(0, 4, 0, 1, 1, "R10");
    chk("R10", {31'd0, alarm_irq_n}, 32'd0);

    // R11 gating
    idle(4, 4, 0, "R11");
    chk("R11", {31'd0, alarm_irq_n}, 32'd1);

    // random mix, R2 map and R3 counting checked against the model
    void'($urandom(32'h5EC0_0A1A));
    for (int i = 0; i < 6000; i++) begin
      automatic logic [3:0] a = 4'($urandom_range(0, 15));
      automatic bit w = ($urandom_range(0, 9) < 2);
      automatic logic [7:0] d = 8'($urandom);
      automatic bit srn = ($urandom_range(0, 49) != 0);
      automatic bit ie = ($urandom_range(0, 4) != 0);
      if (a == 0) d = {($urandom_range(0, 9) != 0), ($urandom_range(0, 5) == 0), 2'b00,
                       ($urandom_range(0, 3) == 0), 3'b000};
      if ((a == 6 || a == 7 || a == 10 || a == 11) && $urandom_range(0, 3) != 0) d = 8'h00;
      step(w, a, d, srn, ie, (a == 0 || a[3:2] == 2'b11 || a < 4) ? "R2" : "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule